// File: doc/BRIEF.md
# Timed-Interrupt Test Coprocessor

This block sits on a processor's coprocessor handshake and serves as a test engine. It holds a file of sixteen 32-bit general registers and a free-running 32-bit cycle counter. The processor presents an instruction word, the coprocessor number it addresses, the class of the instruction and a cycle qualifier. The block answers in the same cycle with a 2-bit response: idle, done, busy (keep going, or more data wanted) or reject (the processor then takes its undefined-instruction trap).

Register moves in both directions are served under two coprocessor numbers (4 and 5). Word loads and stores are served only under number 4. A load or store moves either one word or a burst of five beats. Data-processing operations are decoded from the opcode field. They can hold the processor in busy for a number of cycles taken from a register, and they can pull the active-low fast or normal interrupt line low after a programmed delay. Other operations release those lines, or store the current cycle count into a register. Only one countdown per interrupt line is pending at any time.

Top module: `timed_cop`

## Requirements
- R1: After reset all sixteen registers and the cycle counter read zero, `fiq_n` and `irq_n` are high, and `resp` is idle (00). The counter reads 0 in the first cycle with reset low and adds one every cycle after that.
- R2: A register move (kind 1 writes `wdata`, kind 2 reads onto `rdata` in the same cycle) addresses register `ins_word[19:16]` and answers done under coprocessor number 4 or 5. Under any other number it answers reject (11) and writes nothing.
- R3: Loads (kind 3) and stores (kind 4) address register `ins_word[15:12]` and are served only under coprocessor number 4. Under any other number they answer reject and leave the register unchanged.
- R4: A first or busy cycle of a load or store answers done and restarts the beat count. With `ins_word[22]` clear, a data beat moves one word and answers done. With it set, data beats one to four answer busy and the fifth answers done. Every load beat writes the addressed register.
- R5: Data-processing opcode `ins_word[23:20]` = 0 (either number 4 or 5) is a stall. The delay d is register `ins_word[3:0]`. The first cycle answers done if d is 0 and busy otherwise. The k-th following busy cycle answers busy while k < d and done once k >= d.
- R6: Opcode 1 under number 5 answers done and drives `fiq_n` low from d+1 cycles after the issue cycle, where d is register `ins_word[3:0]`. It stays high before that.
- R7: Opcode 2 under number 5 does the same for `irq_n`.
- R8: Opcode 3 (for `fiq_n`) and opcode 4 (for `irq_n`) under number 5 drive the line high from the next cycle and cancel any pending countdown of that line.
- R9: A new schedule on a line replaces its pending countdown. The line then falls d+1 cycles after the newer issue and not at the older deadline.
- R10: Opcode 5 under number 5 writes the counter value of its issue cycle into register `ins_word[3:0]`.
- R11: Opcodes 6 to 15 under any number, and opcodes 1 to 5 under number 4, answer reject and have no effect on the interrupt lines.
- R12: The encodings are as follows. `resp`: 00 idle, 01 done, 10 busy, 11 reject. `ins_kind`: 0 none, 1 move in, 2 move out, 3 load, 4 store, 5 data op. `cyc_kind`: 0 idle, 1 first, 2 busy, 3 data. When `cyc_kind` is 0 or `ins_kind` is 0, `resp` is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_word | input | 32 | Instruction word presented by the processor |
| cp_sel | input | 4 | Addressed coprocessor number |
| ins_kind | input | 3 | Instruction class |
| cyc_kind | input | 2 | Cycle qualifier |
| wdata | input | 32 | Data from the processor (move in, load beat) |
| rdata | output | 32 | Data to the processor (move out, store beat); zero otherwise |
| resp | output | 2 | Handshake response |
| fiq_n | output | 1 | Active-low fast interrupt request |
| irq_n | output | 1 | Active-low normal interrupt request |

## Verification
The bench builds the block with its default parameters: 32-bit words, coprocessor numbers 4 and 5, and five-beat bursts. At these values, stall and interrupt delays of a few dozen cycles cover the zero-delay path, the one-cycle path and longer countdowns, all within a short run. A five-beat burst is short enough to interrupt it part-way and watch the beat count restart. Counter capture is compared against a cycle count that the bench keeps on its own since reset.

// File: rtl/tcop_pkg.sv
package tcop_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_DONE = 2'd1,
        RSP_BUSY = 2'd2,
        RSP_REJ  = 2'd3
    } rsp_e;

    typedef enum logic [2:0] {
        K_NONE     = 3'd0,
        K_MOVE_IN  = 3'd1,
        K_MOVE_OUT = 3'd2,
        K_LOAD     = 3'd3,
        K_STORE    = 3'd4,
        K_DATAOP   = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        C_IDLE  = 2'd0,
        C_FIRST = 2'd1,
        C_BUSY  = 2'd2,
        C_DATA  = 2'd3
    } cyc_e;

    localparam int SELW = 4;

    localparam logic [3:0] OP_STALL   = 4'd0;
    localparam logic [3:0] OP_FIQ_ARM = 4'd1;
    localparam logic [3:0] OP_IRQ_ARM = 4'd2;
    localparam logic [3:0] OP_FIQ_OFF = 4'd3;
    localparam logic [3:0] OP_IRQ_OFF = 4'd4;
    localparam logic [3:0] OP_STAMP   = 4'd5;

    // Per-cycle control produced by the decoder
    typedef struct packed {
        logic            wen;
        logic            wsel_cnt;
        logic [SELW-1:0] waddr;
        logic [SELW-1:0] raddr;
        logic            rd_en;
        logic            end_load;
        logic            beat_clr;
        logic            beat_inc;
        logic [1:0]      arm;
        logic [1:0]      rel;
    } ctrl_t;

    function automatic logic [SELW-1:0] move_sel(input logic [31:0] ins);
        return ins[19:16];
    endfunction

    function automatic logic [SELW-1:0] xfer_sel(input logic [31:0] ins);
        return ins[15:12];
    endfunction

    function automatic logic [SELW-1:0] arg_sel(input logic [31:0] ins);
        return ins[3:0];
    endfunction

    function automatic logic [3:0] opcode(input logic [31:0] ins);
        return ins[23:20];
    endfunction

endpackage

// File: rtl/tcop_regfile.sv
module tcop_regfile
    import tcop_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = SELW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && waddr == AW'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/tcop_ctrl.sv
module tcop_ctrl
    import tcop_pkg::*;
#(
    parameter int          DW         = 32,
    parameter logic [3:0]  CP_A       = 4'd4,
    parameter logic [3:0]  CP_B       = 4'd5,
    parameter int          LONG_BEATS = 5,
    parameter int          BW         = $clog2(LONG_BEATS + 1)
) (
    input  logic [2:0]    ins_kind,
    input  logic [1:0]    cyc_kind,
    input  logic [3:0]    cp_sel,
    input  logic [31:0]   ins_word,
    input  logic [DW-1:0] delay,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] end_r,
    input  logic [BW-1:0] beats,
    output rsp_e          rsp,
    output ctrl_t         ctl
);
    localparam logic [BW-1:0] LAST_BEAT = BW'(LONG_BEATS - 1);

    kind_e         kind;
    cyc_e          cyc;
    logic          cp_move_ok;
    logic          first;
    logic [3:0]    op;
    logic [DW-1:0] gap;
    logic          reached;

    assign kind       = kind_e'(ins_kind);
    assign cyc        = cyc_e'(cyc_kind);
    assign cp_move_ok = (cp_sel == CP_A) || (cp_sel == CP_B);
    assign first      = (cyc == C_FIRST);
    assign op         = opcode(ins_word);
    // Wrap-safe "counter at or beyond deadline"
    assign gap        = cnt - end_r;
    assign reached    = ~gap[DW-1];

    always_comb begin
        ctl       = '0;
        ctl.raddr = move_sel(ins_word);
        rsp       = RSP_IDLE;
        if (kind != K_NONE && cyc != C_IDLE) begin
            unique case (kind)
                K_MOVE_IN: begin
                    if (cp_move_ok) begin
                        rsp       = RSP_DONE;
                        ctl.wen   = first;
                        ctl.waddr = move_sel(ins_word);
                    end else begin
                        rsp = RSP_REJ;
                    end
                end
                K_MOVE_OUT: begin
                    if (cp_move_ok) begin
                        rsp       = RSP_DONE;
                        ctl.rd_en = 1'b1;
                    end else begin
                        rsp = RSP_REJ;
                    end
                end
                K_LOAD, K_STORE: begin
                    if (cp_sel != CP_A) begin
                        rsp = RSP_REJ;
                    end else begin
                        ctl.raddr = xfer_sel(ins_word);
                        ctl.waddr = xfer_sel(ins_word);
                        if (cyc != C_DATA) begin
                            rsp          = RSP_DONE;
                            ctl.beat_clr = 1'b1;
                        end else begin
                            ctl.wen   = (kind == K_LOAD);
                            ctl.rd_en = (kind == K_STORE);
                            if (!ins_word[22] || beats == LAST_BEAT) begin
                                rsp          = RSP_DONE;
                                ctl.beat_clr = 1'b1;
                            end else begin
                                rsp          = RSP_BUSY;
                                ctl.beat_inc = 1'b1;
                            end
                        end
                    end
                end
                K_DATAOP: begin
                    if (!cp_move_ok) begin
                        rsp = RSP_REJ;
                    end else if (op == OP_STALL) begin
                        if (first) begin
                            ctl.end_load = 1'b1;
                            rsp = (delay == '0) ? RSP_DONE : RSP_BUSY;
                        end else if (cyc == C_BUSY) begin
                            rsp = reached ? RSP_DONE : RSP_BUSY;
                        end else begin
                            rsp = RSP_DONE;
                        end
                    end else if (op <= OP_STAMP && cp_sel == CP_B) begin
                        rsp = RSP_DONE;
                        if (first) begin
                            ctl.arm[0]   = (op == OP_FIQ_ARM);
                            ctl.arm[1]   = (op == OP_IRQ_ARM);
                            ctl.rel[0]   = (op == OP_FIQ_OFF);
                            ctl.rel[1]   = (op == OP_IRQ_OFF);
                            ctl.wen      = (op == OP_STAMP);
                            ctl.wsel_cnt = 1'b1;
                            ctl.waddr    = arg_sel(ins_word);
                        end
                    end else begin
                        rsp = RSP_REJ;
                    end
                end
                default: rsp = RSP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tcop_irq_line.sv
module tcop_irq_line #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          release_req,
    input  logic [DW-1:0] delay,
    output logic          line_n
);
    logic          pend;
    logic [DW-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            rem    <= '0;
            line_n <= 1'b1;
        end else if (release_req) begin
            pend   <= 1'b0;
            line_n <= 1'b1;
        end else if (arm) begin
            if (delay == '0) begin
                pend   <= 1'b0;
                line_n <= 1'b0;
            end else begin
                pend <= 1'b1;
                rem  <= delay;
            end
        end else if (pend) begin
            if (rem == DW'(1)) begin
                pend   <= 1'b0;
                line_n <= 1'b0;
            end else begin
                rem <= rem - DW'(1);
            end
        end
    end

endmodule

// File: rtl/timed_cop.sv
module timed_cop
    import tcop_pkg::*;
#(
    parameter int          DW         = 32,
    parameter logic [3:0]  CP_A       = 4'd4,
    parameter logic [3:0]  CP_B       = 4'd5,
    parameter int          LONG_BEATS = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ins_word,
    input  logic [3:0]  cp_sel,
    input  logic [2:0]  ins_kind,
    input  logic [1:0]  cyc_kind,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [1:0]  resp,
    output logic        fiq_n,
    output logic        irq_n
);
    localparam int BW     = $clog2(LONG_BEATS + 1);
    localparam int NLINES = 2;

    logic [DW-1:0] cnt_q;
    logic [DW-1:0] end_q;
    logic [BW-1:0] beats_q;
    logic [DW-1:0] rd_a;
    logic [DW-1:0] delay_v;
    logic [DW-1:0] wr_val;
    rsp_e          rsp_w;
    ctrl_t         ctl;
    logic [NLINES-1:0] lines_n;

    wire unused_ins = ^{ins_word[31:24], ins_word[21:20], ins_word[11:4]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            end_q   <= '0;
            beats_q <= '0;
        end else begin
            cnt_q <= cnt_q + DW'(1);
            if (ctl.end_load) end_q <= cnt_q + delay_v;
            if (ctl.beat_clr)      beats_q <= '0;
            else if (ctl.beat_inc) beats_q <= beats_q + BW'(1);
        end
    end

    assign wr_val = ctl.wsel_cnt ? cnt_q : wdata;

    tcop_regfile #(.DW(DW), .AW(SELW)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.wen),
        .waddr   (ctl.waddr),
        .wdata   (wr_val),
        .raddr_a (ctl.raddr),
        .rdata_a (rd_a),
        .raddr_b (arg_sel(ins_word)),
        .rdata_b (delay_v)
    );

    tcop_ctrl #(
        .DW(DW), .CP_A(CP_A), .CP_B(CP_B), .LONG_BEATS(LONG_BEATS), .BW(BW)
    ) u_ctrl (
        .ins_kind (ins_kind),
        .cyc_kind (cyc_kind),
        .cp_sel   (cp_sel),
        .ins_word (ins_word),
        .delay    (delay_v),
        .cnt      (cnt_q),
        .end_r    (end_q),
        .beats    (beats_q),
        .rsp      (rsp_w),
        .ctl      (ctl)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        tcop_irq_line #(.DW(DW)) u_line (
            .clk         (clk),
            .rst         (rst),
            .arm         (ctl.arm[g]),
            .release_req (ctl.rel[g]),
            .delay       (delay_v),
            .line_n      (lines_n[g])
        );
    end

    assign fiq_n = lines_n[0];
    assign irq_n = lines_n[1];
    assign rdata = ctl.rd_en ? rd_a : '0;
    assign resp  = rst ? RSP_IDLE : rsp_w;

endmodule

// File: rtl/tcop_checker.sv
module tcop_checker #(
    parameter int         DW   = 32,
    parameter logic [3:0] CP_B = 4'd5
) (
    input logic          clk,
    input logic          rst,
    input logic [31:0]   ins_word,
    input logic [3:0]    cp_sel,
    input logic [2:0]    ins_kind,
    input logic [1:0]    cyc_kind,
    input logic [1:0]    resp,
    input logic          fiq_n,
    input logic          irq_n,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] delay
);
    logic dop_first_b;
    assign dop_first_b = (ins_kind == 3'd5) && (cyc_kind == 2'd1) && (cp_sel == CP_B);

    // R1: lines come out of reset high
    a_r1_lines_high: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fiq_n && irq_n));

    // R1: counter steps by one each cycle out of reset
    a_r1_counter_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt == $past(cnt) + DW'(1)));

    // R3: load/store under the second number is refused
    a_r3_ldst_refused: assert property (@(posedge clk) disable iff (rst)
        ((ins_kind == 3'd3 || ins_kind == 3'd4) && cyc_kind != 2'd0 && cp_sel == CP_B)
        |-> (resp == 2'b11));

    // R6: zero delay pulls fiq low on the next cycle
    a_r6_fiq_zero_delay: assert property (@(posedge clk) disable iff (rst)
        (dop_first_b && ins_word[23:20] == 4'd1 && delay == '0) |=> !fiq_n);

    // R7: zero delay pulls irq low on the next cycle
    a_r7_irq_zero_delay: assert property (@(posedge clk) disable iff (rst)
        (dop_first_b && ins_word[23:20] == 4'd2 && delay == '0) |=> !irq_n);

    // R8: release drives the line high
    a_r8_fiq_release: assert property (@(posedge clk) disable iff (rst)
        (dop_first_b && ins_word[23:20] == 4'd3) |=> fiq_n);

    a_r8_irq_release: assert property (@(posedge clk) disable iff (rst)
        (dop_first_b && ins_word[23:20] == 4'd4) |=> irq_n);

    // R11: unassigned opcodes are refused
    a_r11_bad_op: assert property (@(posedge clk) disable iff (rst)
        (ins_kind == 3'd5 && cyc_kind != 2'd0 && ins_word[23:20] > 4'd5) |-> (resp == 2'b11));

    // R12: idle cycle gives idle response
    a_r12_idle: assert property (@(posedge clk) disable iff (rst)
        (cyc_kind == 2'd0 || ins_kind == 3'd0) |-> (resp == 2'b00));

endmodule

bind timed_cop tcop_checker #(.DW(DW), .CP_B(CP_B)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ins_word (ins_word),
    .cp_sel   (cp_sel),
    .ins_kind (ins_kind),
    .cyc_kind (cyc_kind),
    .resp     (resp),
    .fiq_n    (fiq_n),
    .irq_n    (irq_n),
    .cnt      (cnt_q),
    .delay    (delay_v)
);

// File: tb/timed_cop_bench.sv
`timescale 1ns/1ps
module timed_cop_bench;
    localparam logic [1:0] IDL = 2'd0, DON = 2'd1, BSY = 2'd2, REJ = 2'd3;
    localparam logic [2:0] KMI = 3'd1, KMO = 3'd2, KLD = 3'd3, KST = 3'd4, KDP = 3'd5;
    localparam logic [1:0] CF = 2'd1, CB = 2'd2, CD = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ins_word = '0;
    logic [3:0]  cp_sel = '0;
    logic [2:0]  ins_kind = '0;
    logic [1:0]  cyc_kind = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  resp;
    logic        fiq_n, irq_n;

    int errs = 0;
    int nchk = 0;
    logic [31:0] bcnt = '0;
    logic [31:0] sh [16];

    timed_cop u_timed_cop (
        .clk(clk), .rst(rst), .ins_word(ins_word), .cp_sel(cp_sel),
        .ins_kind(ins_kind), .cyc_kind(cyc_kind), .wdata(wdata),
        .rdata(rdata), .resp(resp), .fiq_n(fiq_n), .irq_n(irq_n)
    );

    always #10 clk = ~clk;

    always @(posedge clk) bcnt <= rst ? 32'd0 : bcnt + 32'd1;

    function automatic logic [31:0] i_mov(input logic [3:0] rn);
        return {12'h0, rn, 16'h0};
    endfunction
    function automatic logic [31:0] i_ls(input logic [3:0] rd, input logic lng);
        return {9'h0, lng, 6'h0, rd, 12'h0};
    endfunction
    function automatic logic [31:0] i_dp(input logic [3:0] op, input logic [3:0] rm);
        return {8'h0, op, 16'h0, rm};
    endfunction
    function automatic logic [1:0] stall_exp(input int k, input int d);
        return (k >= d) ? DON : BSY;
    endfunction

    task automatic drive(input logic [2:0] k, input logic [3:0] cp, input logic [1:0] c,
                         input logic [31:0] ins, input logic [31:0] wd);
        @(negedge clk);
        ins_kind = k; cp_sel = cp; cyc_kind = c; ins_word = ins; wdata = wd;
        #5;
    endtask

    task automatic idle();
        drive(3'd0, 4'd0, 2'd0, 32'd0, 32'd0);
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wreg(input logic [3:0] r, input logic [31:0] v, input logic [3:0] cp);
        drive(KMI, cp, CF, i_mov(r), v);
        sh[r] = v;
    endtask

    task automatic rdchk(input string rq, input logic [3:0] r);
        drive(KMO, 4'd4, CF, i_mov(r), 32'd0);
        chk(rq, rdata, sh[r]);
    endtask

    // schedule on line sel (0 fiq,1 irq) with delay d, then check timing
    task automatic line_test(input string rq, input int sel, input int d);
        logic ln;
        wreg(4'd9, 32'(d), 4'd5);
        drive(KDP, 4'd5, CF, i_dp(sel == 0 ? 4'd1 : 4'd2, 4'd9), 32'd0);
        chk({rq, " issue resp"}, 32'(resp), 32'(DON));
        for (int j = 1; j <= d + 1; j++) begin
            idle();
            ln = (sel == 0) ? fiq_n : irq_n;
            if (j == d)     chk({rq, " still high"}, 32'(ln), 32'd1);
            if (j == d + 1) chk({rq, " low"}, 32'(ln), 32'd0);
        end
        drive(KDP, 4'd5, CF, i_dp(sel == 0 ? 4'd3 : 4'd4, 4'd0), 32'd0);
        idle();
        ln = (sel == 0) ? fiq_n : irq_n;
        chk("R8 release", 32'(ln), 32'd1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) sh[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #5;
        // R1 reset state
        chk("R1 resp idle", 32'(resp), 32'(IDL));
        chk("R1 fiq high", 32'(fiq_n), 32'd1);
        chk("R1 irq high", 32'(irq_n), 32'd1);
        for (int r = 0; r < 16; r++) rdchk("R1 reg zero", 4'(r));

        // R2 random moves under both numbers
        for (int i = 0; i < 40; i++) begin
            logic [3:0] r;
            logic [3:0] cp;
            logic [31:0] v;
            r = 4'($urandom_range(0, 15));
            cp = ($urandom_range(0, 1) == 0) ? 4'd4 : 4'd5;
            v = $urandom;
            drive(KMI, cp, CF, i_mov(r), v);
            chk("R2 move in resp", 32'(resp), 32'(DON));
            sh[r] = v;
            r = 4'($urandom_range(0, 15));
            drive(KMO, cp, CF, i_mov(r), 32'd0);
            chk("R2 move out", rdata, sh[r]);
        end
        drive(KMI, 4'd7, CF, i_mov(4'd3), 32'hDEAD_BEEF);
        chk("R2 other number reject", 32'(resp), 32'(REJ));
        rdchk("R2 no write on reject", 4'd3);

        // R3/R4 single load and store
        drive(KLD, 4'd4, CF, i_ls(4'd6, 1'b0), 32'd0);
        chk("R4 first cycle done", 32'(resp), 32'(DON));
        drive(KLD, 4'd4, CD, i_ls(4'd6, 1'b0), 32'h1234_5678);
        chk("R4 single beat done", 32'(resp), 32'(DON));
        sh[6] = 32'h1234_5678;
        rdchk("R3 load target", 4'd6);
        drive(KST, 4'd4, CD, i_ls(4'd6, 1'b0), 32'd0);
        chk("R3 store data", rdata, 32'h1234_5678);
        drive(KLD, 4'd5, CD, i_ls(4'd6, 1'b0), 32'hFFFF_0000);
        chk("R3 load cp5 reject", 32'(resp), 32'(REJ));
        rdchk("R3 unchanged", 4'd6);
        drive(KST, 4'd5, CD, i_ls(4'd6, 1'b0), 32'd0);
        chk("R3 store cp5 reject", 32'(resp), 32'(REJ));

        // R4 long burst, interrupted then full
        drive(KLD, 4'd4, CF, i_ls(4'd2, 1'b1), 32'd0);
        for (int b = 1; b <= 2; b++) begin
            drive(KLD, 4'd4, CD, i_ls(4'd2, 1'b1), 32'(b));
            chk("R4 early beat busy", 32'(resp), 32'(BSY));
        end
        drive(KLD, 4'd4, CF, i_ls(4'd2, 1'b1), 32'd0);
        for (int b = 1; b <= 5; b++) begin
            drive(KLD, 4'd4, CD, i_ls(4'd2, 1'b1), 32'hA0 + 32'(b));
            chk("R4 burst beat", 32'(resp), 32'(b == 5 ? DON : BSY));
        end
        sh[2] = 32'hA5;
        rdchk("R4 burst last word", 4'd2);
        drive(KST, 4'd4, CB, i_ls(4'd2, 1'b1), 32'd0);
        for (int b = 1; b <= 5; b++) begin
            drive(KST, 4'd4, CD, i_ls(4'd2, 1'b1), 32'd0);
            chk("R4 store burst resp", 32'(resp), 32'(b == 5 ? DON : BSY));
            chk("R4 store burst data", rdata, 32'hA5);
        end

        // R5 stalls with random delays
        for (int i = 0; i < 8; i++) begin
            int d;
            logic [3:0] cp;
            d = (i == 0) ? 0 : (i == 1) ? 1 : $urandom_range(2, 12);
            cp = (i % 2 == 0) ? 4'd4 : 4'd5;
            wreg(4'd11, 32'(d), cp);
            drive(KDP, cp, CF, i_dp(4'd0, 4'd11), 32'd0);
            chk("R5 stall first", 32'(resp), 32'(stall_exp(0, d)));
            for (int k = 1; k <= d; k++) begin
                drive(KDP, cp, CB, i_dp(4'd0, 4'd11), 32'd0);
                chk("R5 stall poll", 32'(resp), 32'(stall_exp(k, d)));
            end
        end

        // R6/R7 timed lines
        line_test("R6 fiq", 0, 0);
        line_test("R6 fiq", 0, 1);
        line_test("R6 fiq", 0, $urandom_range(2, 9));
        line_test("R7 irq", 1, 0);
        line_test("R7 irq", 1, $urandom_range(2, 9));

        // R9 replace pending countdown
        wreg(4'd9, 32'd10, 4'd5);
        wreg(4'd8, 32'd2, 4'd5);
        drive(KDP, 4'd5, CF, i_dp(4'd1, 4'd9), 32'd0);
        idle(); idle();
        drive(KDP, 4'd5, CF, i_dp(4'd1, 4'd8), 32'd0);
        idle(); idle();
        chk("R9 high before new deadline", 32'(fiq_n), 32'd1);
        idle();
        chk("R9 low at new deadline", 32'(fiq_n), 32'd0);
        drive(KDP, 4'd5, CF, i_dp(4'd3, 4'd0), 32'd0);

        // R8 cancel pending
        wreg(4'd9, 32'd5, 4'd5);
        drive(KDP, 4'd5, CF, i_dp(4'd2, 4'd9), 32'd0);
        idle();
        drive(KDP, 4'd5, CF, i_dp(4'd4, 4'd0), 32'd0);
        for (int j = 0; j < 8; j++) idle();
        chk("R8 cancelled irq stays high", 32'(irq_n), 32'd1);

        // R10 counter capture
        for (int i = 0; i < 3; i++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            drive(KDP, 4'd5, CF, i_dp(4'd5, r), 32'd0);
            chk("R10 capture resp", 32'(resp), 32'(DON));
            sh[r] = bcnt;
            repeat ($urandom_range(0, 4)) idle();
            rdchk("R10 captured count", r);
        end

        // R11 rejects
        wreg(4'd1, 32'd0, 4'd4);
        for (int i = 0; i < 6; i++) begin
            drive(KDP, 4'd5, CF, i_dp(4'($urandom_range(6, 15)), 4'd1), 32'd0);
            chk("R11 bad opcode", 32'(resp), 32'(REJ));
        end
        drive(KDP, 4'd4, CF, i_dp(4'd1, 4'd1), 32'd0);
        chk("R11 fiq op under cp4", 32'(resp), 32'(REJ));
        drive(KDP, 4'd4, CF, i_dp(4'd2, 4'd1), 32'd0);
        chk("R11 irq op under cp4", 32'(resp), 32'(REJ));
        idle(); idle();
        chk("R11 fiq untouched", 32'(fiq_n), 32'd1);
        chk("R11 irq untouched", 32'(irq_n), 32'd1);

        // R12 idle qualifier
        drive(KMO, 4'd4, 2'd0, i_mov(4'd2), 32'd0);
        chk("R12 idle cycle", 32'(resp), 32'(IDL));
        drive(3'd0, 4'd4, CF, i_mov(4'd2), 32'd0);
        chk("R12 no kind", 32'(resp), 32'(IDL));

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule